// File: doc/BRIEF.md
# Level-Interrupt EOI Handler with Storm Throttling

This block services end-of-interrupt broadcasts for a bank of interrupt redirection entries. Each broadcast carries a vector and a message type (level or edge). The block walks every pin, one per cycle in ascending order, and compares each entry's vector with the broadcast. Every match raises an acknowledge strobe. A level broadcast, when directed-EOI mode is off, also clears the entry's remote-pending flag through a strobe and may ask for the pin to be delivered again. Entry storage and message delivery sit outside the block. It reads the entry fields and line request bits as flat input vectors and drives one-cycle strobes, each with a pin index.

A level line that stays asserted while software acknowledges it without clearing the cause can redeliver without end. The block counts back-to-back redeliveries for each pin. When a pin's count reaches a threshold, the block does not redeliver at once. It zeroes that count and arms a single delay timer, nominally 10 ms, which is converted to cycles from a clock frequency parameter. When the timer runs out, a sweep over all pins asks for service on every level entry that has a pending request and no remote-pending flag.

Top module: `eoi_storm_ctrl`

## Requirements
- R1: An accepted broadcast raises `ack_valid` with `ack_pin` once for every pin whose `ent_vector` field (pin i at bits [i*VEC_W +: VEC_W]) equals `eoi_vector`. This holds for either value of `eoi_level` and `directed_eoi` and for either entry trigger type. Non-matching pins raise nothing.
- R2: When `eoi_level` is 0 (edge message) or `directed_eoi` is 1, a broadcast produces no clear or service strobe and leaves every successive counter unchanged.
- R3: A level broadcast (`eoi_level`=1) with `directed_eoi`=0 raises `clr_valid` with `clr_pin` for every matching pin, in the same cycle as that pin's acknowledge.
- R4: After such a clear, a matching pin with `ent_mask` bit 0 (unmasked) and `line_req` bit 1 has its successive counter incremented. If the new count is below STORM_LIMIT, the pin gets a `svc_valid` strobe in the same cycle.
- R5: When the increment would make the count reach STORM_LIMIT, no service strobe is raised, the count returns to 0, and a sweep is scheduled CLK_HZ/SWEEP_DIV cycles later. No service comes from the sweep before that many cycles have passed.
- R6: After a clear, a matching pin that is masked (`ent_mask`=1) or whose `line_req` bit is 0 gets no service strobe, and its counter returns to 0.
- R7: A sweep raises `svc_valid` exactly once for every pin with `ent_level`=1 (level), `line_req`=1 and `ent_remote`=0, and for no other pin. It raises no acknowledge or clear strobe and leaves the counters alone.
- R8: Scheduling a sweep while one is already pending neither restarts nor adds to the timer, so only one sweep runs, timed from the first schedule.
- R9: An accepted broadcast holds `busy` high for exactly NPINS cycles while pins are visited in ascending order. A broadcast offered while `busy` is high is ignored.
- R10: Synchronous reset (`rst`=1) drops `busy` and all strobes, zeroes every successive counter, and cancels a pending sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoi_valid | input | 1 | Broadcast offered this cycle |
| eoi_vector | input | VEC_W | Broadcast vector |
| eoi_level | input | 1 | 1 = level message, 0 = edge message |
| directed_eoi | input | 1 | 1 = directed-EOI mode; suppresses clearing and redelivery |
| ent_vector | input | NPINS*VEC_W | Entry vectors, pin i in slice i |
| ent_level | input | NPINS | Entry trigger type, 1 = level |
| ent_mask | input | NPINS | Entry mask, 1 = masked |
| ent_remote | input | NPINS | Entry remote-pending flag |
| line_req | input | NPINS | Request bit of each line |
| busy | output | 1 | Scan or sweep in progress |
| ack_valid | output | 1 | Acknowledge strobe |
| ack_pin | output | PIN_W | Pin being acknowledged |
| clr_valid | output | 1 | Clear-remote-pending strobe |
| clr_pin | output | PIN_W | Pin whose remote-pending flag is cleared |
| svc_valid | output | 1 | Service (redeliver) strobe |
| svc_pin | output | PIN_W | Pin to be serviced |

## Verification
The hardest state to reach is a pin arriving at its threshold while the timer is already armed by another pin. That needs one pin driven through a full run of back-to-back level broadcasts, followed by a second pin's complete run, all inside a single delay window. The bench sets the threshold to 4 and the delay to a few hundred cycles. It then drives the two storms back to back and times the single sweep against the first schedule. Counter persistence is shown by interleaving directed and edge broadcasts, dropped requests and a mid-window reset, and then counting how many redeliveries happen before the next deferral.

// File: rtl/eoi_storm_pkg.sv
package eoi_storm_pkg;

    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,
        SCAN_EOI   = 2'd1,
        SCAN_SWEEP = 2'd2
    } scan_mode_e;

    // Decision for the pin under the scan pointer in the current cycle.
    typedef struct packed {
        logic ack;    // acknowledge strobe
        logic clr;    // clear remote-pending strobe
        logic svc;    // service / redeliver strobe
        logic bump;   // increment successive counter
        logic zero;   // zero successive counter
        logic defer;  // arm the deferred sweep
    } pin_action_t;

    function automatic pin_action_t eoi_action(
        input logic hit,
        input logic msg_level,
        input logic directed,
        input logic masked,
        input logic req,
        input logic at_limit
    );
        pin_action_t a;
        a = '0;
        if (hit) begin
            a.ack = 1'b1;
            if (msg_level && !directed) begin
                a.clr = 1'b1;
                if (!masked && req) begin
                    if (at_limit) begin
                        a.zero  = 1'b1;
                        a.defer = 1'b1;
                    end else begin
                        a.bump = 1'b1;
                        a.svc  = 1'b1;
                    end
                end else begin
                    a.zero = 1'b1;
                end
            end
        end
        return a;
    endfunction

    function automatic pin_action_t sweep_action(
        input logic ent_is_level,
        input logic req,
        input logic remote
    );
        pin_action_t a;
        a = '0;
        a.svc = ent_is_level && req && !remote;
        return a;
    endfunction

    function automatic int cycles_for_period(input longint hz, input longint div);
        longint c;
        c = hz / div;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/eoi_storm_counters.sv
module eoi_storm_counters #(
    parameter int NPINS = 24,
    parameter int LIMIT = 10000,
    parameter int PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] sel,
    input  logic             bump,
    input  logic             zero,
    output logic             at_limit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt [NPINS];

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_cnt
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt[g] <= '0;
                end else if (sel == PIN_W'(g)) begin
                    if (zero) begin
                        cnt[g] <= '0;
                    end else if (bump) begin
                        cnt[g] <= cnt[g] + CW'(1);
                    end
                end
            end

            // A counter is zeroed in place of reaching the threshold.
            assert_cnt_below_limit_R5: assert property (@(posedge clk) disable iff (rst)
                cnt[g] < CW'(LIMIT));
        end
    endgenerate

    always_comb begin
        at_limit = 1'b0;
        if (int'(sel) < NPINS) begin
            at_limit = (cnt[sel] == CW'(LIMIT - 1));
        end
    end

endmodule

// File: rtl/eoi_sweep_timer.sv
module eoi_sweep_timer #(
    parameter int DELAY = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic take,
    output logic due
);
    localparam int TW = $clog2(DELAY + 1);

    logic          pending_q;
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            cnt_q     <= '0;
            due       <= 1'b0;
        end else begin
            if (take) begin
                due <= 1'b0;
            end
            if (pending_q) begin
                if (cnt_q == '0) begin
                    pending_q <= 1'b0;
                    due       <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - TW'(1);
                end
            end else if (arm) begin
                pending_q <= 1'b1;
                cnt_q     <= TW'(DELAY - 1);
            end
        end
    end

    // A second arm while pending must not reload the countdown.
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (pending_q && $past(pending_q)) |-> (cnt_q == TW'($past(cnt_q) - TW'(1))));

    assert_due_after_count_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(due) |-> $past(pending_q));

endmodule

// File: rtl/eoi_pin_scanner.sv
module eoi_pin_scanner
    import eoi_storm_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int VEC_W = 8,
    parameter int PIN_W = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vector,
    input  logic                   eoi_level,
    input  logic                   directed_eoi,
    input  logic [NPINS*VEC_W-1:0] ent_vector,
    input  logic [NPINS-1:0]       ent_level,
    input  logic [NPINS-1:0]       ent_mask,
    input  logic [NPINS-1:0]       ent_remote,
    input  logic [NPINS-1:0]       line_req,
    input  logic                   at_limit,
    input  logic                   sweep_due,
    output logic [PIN_W-1:0]       sel,
    output logic                   cnt_bump,
    output logic                   cnt_zero,
    output logic                   timer_arm,
    output logic                   sweep_take,
    output logic                   busy,
    output logic                   ack_valid,
    output logic [PIN_W-1:0]       ack_pin,
    output logic                   clr_valid,
    output logic [PIN_W-1:0]       clr_pin,
    output logic                   svc_valid,
    output logic [PIN_W-1:0]       svc_pin
);
    scan_mode_e       mode_q;
    logic [PIN_W-1:0] idx_q;
    logic [VEC_W-1:0] vec_q;
    logic             lvl_q;
    logic             dir_q;
    logic [VEC_W-1:0] cur_vec;
    logic             last_pin;
    pin_action_t      act;

    assign cur_vec  = ent_vector[int'(idx_q)*VEC_W +: VEC_W];
    assign last_pin = (idx_q == PIN_W'(NPINS - 1));
    assign sel      = idx_q;
    assign busy     = (mode_q != SCAN_IDLE);

    always_comb begin
        unique case (mode_q)
            SCAN_EOI:   act = eoi_action(cur_vec == vec_q, lvl_q, dir_q,
                                         ent_mask[idx_q], line_req[idx_q], at_limit);
            SCAN_SWEEP: act = sweep_action(ent_level[idx_q], line_req[idx_q],
                                           ent_remote[idx_q]);
            default:    act = '0;
        endcase
    end

    assign cnt_bump   = act.bump;
    assign cnt_zero   = act.zero;
    assign timer_arm  = act.defer;
    assign sweep_take = (mode_q == SCAN_IDLE) && !eoi_valid && sweep_due;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= SCAN_IDLE;
            idx_q     <= '0;
            vec_q     <= '0;
            lvl_q     <= 1'b0;
            dir_q     <= 1'b0;
            ack_valid <= 1'b0;
            ack_pin   <= '0;
            clr_valid <= 1'b0;
            clr_pin   <= '0;
            svc_valid <= 1'b0;
            svc_pin   <= '0;
        end else begin
            ack_valid <= act.ack;
            ack_pin   <= idx_q;
            clr_valid <= act.clr;
            clr_pin   <= idx_q;
            svc_valid <= act.svc;
            svc_pin   <= idx_q;
            if (mode_q == SCAN_IDLE) begin
                idx_q <= '0;
                if (eoi_valid) begin
                    mode_q <= SCAN_EOI;
                    vec_q  <= eoi_vector;
                    lvl_q  <= eoi_level;
                    dir_q  <= directed_eoi;
                end else if (sweep_due) begin
                    mode_q <= SCAN_SWEEP;
                end
            end else if (last_pin) begin
                mode_q <= SCAN_IDLE;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + PIN_W'(1);
            end
        end
    end

    assert_svc_inside_scan_R9: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> $past(busy));

    assert_ack_ascending_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && $past(ack_valid)) |-> (ack_pin > $past(ack_pin)));

    assert_clr_with_ack_R3: assert property (@(posedge clk) disable iff (rst)
        clr_valid |-> (ack_valid && (clr_pin == ack_pin)));

    assert_sweep_silent_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == SCAN_SWEEP) |-> !ack_valid && !clr_valid);

endmodule

// File: rtl/eoi_storm_ctrl.sv
module eoi_storm_ctrl
    import eoi_storm_pkg::*;
#(
    parameter int NPINS       = 24,
    parameter int VEC_W       = 8,
    parameter int STORM_LIMIT = 10000,
    parameter int CLK_HZ      = 125000000,
    parameter int SWEEP_DIV   = 100,
    localparam int PIN_W      = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vector,
    input  logic                   eoi_level,
    input  logic                   directed_eoi,
    input  logic [NPINS*VEC_W-1:0] ent_vector,
    input  logic [NPINS-1:0]       ent_level,
    input  logic [NPINS-1:0]       ent_mask,
    input  logic [NPINS-1:0]       ent_remote,
    input  logic [NPINS-1:0]       line_req,
    output logic                   busy,
    output logic                   ack_valid,
    output logic [PIN_W-1:0]       ack_pin,
    output logic                   clr_valid,
    output logic [PIN_W-1:0]       clr_pin,
    output logic                   svc_valid,
    output logic [PIN_W-1:0]       svc_pin
);
    localparam int DELAY_CYC = cycles_for_period(longint'(CLK_HZ), longint'(SWEEP_DIV));

    logic [PIN_W-1:0] sel;
    logic             cnt_bump;
    logic             cnt_zero;
    logic             at_limit;
    logic             timer_arm;
    logic             sweep_take;
    logic             sweep_due;

    eoi_pin_scanner #(
        .NPINS (NPINS),
        .VEC_W (VEC_W),
        .PIN_W (PIN_W)
    ) u_scan (
        .clk          (clk),
        .rst          (rst),
        .eoi_valid    (eoi_valid),
        .eoi_vector   (eoi_vector),
        .eoi_level    (eoi_level),
        .directed_eoi (directed_eoi),
        .ent_vector   (ent_vector),
        .ent_level    (ent_level),
        .ent_mask     (ent_mask),
        .ent_remote   (ent_remote),
        .line_req     (line_req),
        .at_limit     (at_limit),
        .sweep_due    (sweep_due),
        .sel          (sel),
        .cnt_bump     (cnt_bump),
        .cnt_zero     (cnt_zero),
        .timer_arm    (timer_arm),
        .sweep_take   (sweep_take),
        .busy         (busy),
        .ack_valid    (ack_valid),
        .ack_pin      (ack_pin),
        .clr_valid    (clr_valid),
        .clr_pin      (clr_pin),
        .svc_valid    (svc_valid),
        .svc_pin      (svc_pin)
    );

    eoi_storm_counters #(
        .NPINS (NPINS),
        .LIMIT (STORM_LIMIT),
        .PIN_W (PIN_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .bump     (cnt_bump),
        .zero     (cnt_zero),
        .at_limit (at_limit)
    );

    eoi_sweep_timer #(
        .DELAY (DELAY_CYC)
    ) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .arm  (timer_arm),
        .take (sweep_take),
        .due  (sweep_due)
    );

endmodule

// File: tb/eoi_storm_ctrl_bench.sv
module eoi_storm_ctrl_bench;
    localparam int N     = 8;
    localparam int VW    = 8;
    localparam int LIM   = 4;
    localparam int HZ    = 30000;
    localparam int DIV   = 100;
    localparam int D     = HZ / DIV;
    localparam int PW    = $clog2(N);
    localparam int WIN   = 2 * N + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic          eoi_valid = 1'b0;
    logic [VW-1:0] eoi_vector = '0;
    logic          eoi_level = 1'b0;
    logic          directed_eoi = 1'b0;
    logic [VW-1:0] e_vec [N];
    logic [N-1:0]  e_lvl, e_msk, e_rem, e_req;
    logic [N*VW-1:0] ent_vector;
    logic busy, ack_valid, clr_valid, svc_valid;
    logic [PW-1:0] ack_pin, clr_pin, svc_pin;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) ent_vector[i*VW +: VW] = e_vec[i];
    end

    eoi_storm_ctrl #(
        .NPINS(N), .VEC_W(VW), .STORM_LIMIT(LIM), .CLK_HZ(HZ), .SWEEP_DIV(DIV)
    ) u_eoi_storm_ctrl (
        .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .eoi_level(eoi_level), .directed_eoi(directed_eoi), .ent_vector(ent_vector),
        .ent_level(e_lvl), .ent_mask(e_msk), .ent_remote(e_rem), .line_req(e_req),
        .busy(busy), .ack_valid(ack_valid), .ack_pin(ack_pin), .clr_valid(clr_valid),
        .clr_pin(clr_pin), .svc_valid(svc_valid), .svc_pin(svc_pin)
    );

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int ack_n [N];
    int clr_n [N];
    int svc_n [N];
    int svc_t [N];
    int busy_cyc = 0;
    int order_bad = 0;
    bit prev_ack = 1'b0;
    int prev_pin = 0;
    int ta = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cyc++;
            if (ack_valid) begin
                ack_n[ack_pin]++;
                if (prev_ack && int'(ack_pin) <= prev_pin) order_bad++;
            end
            if (clr_valid) clr_n[clr_pin]++;
            if (svc_valid) begin
                svc_n[svc_pin]++;
                svc_t[svc_pin] = cyc;
            end
            prev_ack = ack_valid;
            prev_pin = int'(ack_pin);
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int total(input int a [N]);
        int s = 0;
        for (int i = 0; i < N; i++) s += a[i];
        return s;
    endfunction

    task automatic clear_logs();
        for (int i = 0; i < N; i++) begin
            ack_n[i] = 0; clr_n[i] = 0; svc_n[i] = 0; svc_t[i] = 0;
        end
        busy_cyc = 0;
        order_bad = 0;
    endtask

    task automatic init_entries();
        for (int i = 0; i < N; i++) e_vec[i] = VW'(8'h40 + i);
        e_lvl = '0; e_msk = '1; e_rem = '0; e_req = '0;
    endtask

    task automatic set_entry(input int p, input int v, input bit lvl, input bit msk,
                             input bit rem, input bit req);
        e_vec[p] = VW'(v); e_lvl[p] = lvl; e_msk[p] = msk; e_rem[p] = rem; e_req[p] = req;
    endtask

    task automatic do_eoi(input int v, input bit lvl, input bit dir);
        @(negedge clk);
        while (busy) @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = VW'(v); eoi_level = lvl; directed_eoi = dir;
        @(negedge clk);
        ta = cyc;
        eoi_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic t_reset();
        check_eq("R10 busy after reset", int'(busy), 0);
        check_eq("R10 ack after reset", int'(ack_valid), 0);
        check_eq("R10 clr after reset", int'(clr_valid), 0);
        check_eq("R10 svc after reset", int'(svc_valid), 0);
    endtask

    task automatic t_ack_any_mode();
        init_entries();
        set_entry(2, 'h55, 0, 0, 0, 1);
        set_entry(5, 'h55, 1, 0, 0, 1);
        clear_logs();
        do_eoi('h55, 0, 0);
        check_eq("R1 ack edge-type pin2", ack_n[2], 1);
        check_eq("R1 ack level-type pin5", ack_n[5], 1);
        check_eq("R1 ack total", total(ack_n), 2);
        check_eq("R2 edge msg no clear", total(clr_n), 0);
        check_eq("R2 edge msg no service", total(svc_n), 0);
    endtask

    task automatic t_level_eoi();
        init_entries();
        set_entry(1, 'h60, 1, 0, 0, 1);
        set_entry(3, 'h60, 1, 1, 0, 1);
        set_entry(6, 'h60, 1, 0, 0, 0);
        clear_logs();
        do_eoi('h60, 1, 0);
        check_eq("R1 ack total level", total(ack_n), 3);
        check_eq("R3 clear pin1", clr_n[1], 1);
        check_eq("R3 clear pin3", clr_n[3], 1);
        check_eq("R3 clear pin6", clr_n[6], 1);
        check_eq("R4 service pin1", svc_n[1], 1);
        check_eq("R6 masked or idle pins not serviced", total(svc_n), 1);
        check_eq("R9 busy length", busy_cyc, N);
        check_eq("R9 ascending order", order_bad, 0);
    endtask

    task automatic t_directed();
        clear_logs();
        do_eoi('h60, 1, 1);
        check_eq("R1 ack in directed mode", total(ack_n), 3);
        check_eq("R2 directed no clear", total(clr_n), 0);
        check_eq("R2 directed no service", total(svc_n), 0);
    endtask

    task automatic t_storm();
        init_entries();
        set_entry(4, 'h70, 1, 0, 0, 1);
        set_entry(2, 'h20, 1, 0, 1, 1);
        set_entry(5, 'h21, 0, 0, 0, 1);
        set_entry(6, 'h22, 1, 1, 0, 1);
        clear_logs();
        for (int k = 0; k < 3; k++) do_eoi('h70, 1, 0);
        check_eq("R4 three redeliveries", svc_n[4], 3);
        do_eoi('h70, 1, 1);
        clear_logs();
        do_eoi('h70, 1, 0);
        begin
            int t0 = ta;
            check_eq("R5 threshold defers service", svc_n[4], 0);
            check_eq("R3 clear still raised at threshold", clr_n[4], 1);
            clear_logs();
            do_eoi('h70, 1, 0);
            check_eq("R5 counter restarted", svc_n[4], 1);
            clear_logs();
            wait_until(t0 + D - 1);
            check_eq("R5 no sweep before delay", total(svc_n), 0);
            wait_until(t0 + D + WIN);
            check_eq("R7 sweep pin4", svc_n[4], 1);
            check_eq("R7 sweep level masked pin6", svc_n[6], 1);
            check_eq("R7 sweep skips remote pin2", svc_n[2], 0);
            check_eq("R7 sweep skips edge pin5", svc_n[5], 0);
            check_eq("R7 sweep total", total(svc_n), 2);
            check_eq("R7 sweep no ack", total(ack_n), 0);
            check_eq("R5 sweep not early", int'(svc_t[4] >= t0 + D), 1);
        end
        wait_until(cyc + WIN);
    endtask

    task automatic t_req_drop();
        clear_logs();
        do_eoi('h70, 1, 0);
        do_eoi('h70, 1, 0);
        check_eq("R4 pre-drop services", svc_n[4], 2);
        e_req[4] = 1'b0;
        clear_logs();
        do_eoi('h70, 1, 0);
        check_eq("R6 no service without request", svc_n[4], 0);
        e_req[4] = 1'b1;
        clear_logs();
        for (int k = 0; k < 3; k++) do_eoi('h70, 1, 0);
        check_eq("R6 counter zeroed by idle line", svc_n[4], 3);
    endtask

    task automatic t_no_restart();
        set_entry(7, 'h71, 1, 0, 0, 1);
        clear_logs();
        do_eoi('h70, 1, 0);
        begin
            int t0 = ta;
            check_eq("R5 pin4 deferred", svc_n[4], 0);
            for (int k = 0; k < 4; k++) do_eoi('h71, 1, 0);
            check_eq("R5 pin7 three then deferred", svc_n[7], 3);
            clear_logs();
            wait_until(t0 + D + WIN);
            check_eq("R8 sweep timed from first arm", svc_n[4], 1);
            wait_until(t0 + 2 * D + 2 * WIN);
            check_eq("R8 single sweep", svc_n[4], 1);
        end
    endtask

    task automatic t_busy_ignore();
        init_entries();
        set_entry(1, 'h60, 1, 0, 0, 1);
        set_entry(3, 'h61, 1, 0, 0, 1);
        clear_logs();
        @(negedge clk);
        while (busy) @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = 8'h60; eoi_level = 1'b1; directed_eoi = 1'b0;
        @(negedge clk);
        eoi_vector = 8'h61;
        repeat (3) @(negedge clk);
        eoi_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check_eq("R9 accepted broadcast acked", ack_n[1], 1);
        check_eq("R9 broadcast while busy ignored", ack_n[3], 0);
    endtask

    task automatic t_reset_cancel();
        init_entries();
        set_entry(4, 'h70, 1, 0, 0, 1);
        set_entry(7, 'h71, 1, 0, 0, 1);
        // Both counters are 0 here: pin4 zeroed at its deferral, pin7 too.
        do_eoi('h71, 1, 0);
        do_eoi('h71, 1, 0);
        clear_logs();
        for (int k = 0; k < 4; k++) do_eoi('h70, 1, 0);
        check_eq("R5 storm before reset", svc_n[4], 3);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_eq("R10 busy low after reset", int'(busy), 0);
        clear_logs();
        repeat (D + 2 * WIN) @(negedge clk);
        check_eq("R10 pending sweep cancelled", total(svc_n), 0);
        for (int k = 0; k < 3; k++) do_eoi('h71, 1, 0);
        check_eq("R10 counters zeroed", svc_n[7], 3);
        clear_logs();
        do_eoi('h71, 1, 0);
        check_eq("R5 threshold after reset", svc_n[7], 0);
    endtask

    initial begin
        init_entries();
        clear_logs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ack_any_mode();
        t_level_eoi();
        t_directed();
        t_storm();
        t_req_drop();
        t_no_restart();
        t_busy_ignore();
        t_reset_cancel();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule